// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture

This block records the current 64-bit time value when an event packet starts on the transmit or the receive side of the MAC. Each direction owns one capture slot. A capture locks the slot, and while the stamp waits to be read no later packet in that direction is stamped. Software fetches the stamp through a small register port, low word first and then high word. Reading the high word unlocks the slot for the next capture.

A transmit capture is armed only by its enable bit. A receive capture also needs the packet to qualify. It can qualify by a programmable Ethertype, which needs both a filter-enable and a stamp-enable bit. It can qualify as a UDP event message, meaning IP protocol 17 and destination port 319. A third mode stamps every received packet. Header parsing and the time counter sit outside the block; it takes their results as inputs.

Top module: `pkt_stamp_capture`

## Requirements
- R1: Each direction has one slot. While its valid flag is 1, start-of-frame strobes in that direction change neither the stamp nor the flag.
- R2: A `tx_sof` pulse, with the transmit enable set and the slot empty, loads the `time_now` value present at that clock edge into `tx_stamp` and sets `tx_valid`, both visible after that edge.
- R3: Register reads return data combinationally in the cycle of the read, as follows. Address 0 is transmit control: bit 0 is the enable, bit 1 is the valid flag. Address 1 is receive control: bit 0 enable, bit 1 valid, bit 2 stamp-all, bit 3 Ethertype filter enable, bit 4 Ethertype stamp enable, bit 5 UDP event enable. Address 2 bits 15:0 hold the Ethertype. Addresses 3 and 4 hold the transmit stamp, low word then high word. Addresses 5 and 6 hold the receive stamp, low word then high word. Address 7 reads 0.
- R4: A read of address 4 (or 6) while the matching slot is valid clears that valid flag at the clock edge. A read of address 3 (or 5) leaves the slot locked.
- R5: With the enable bit (bit 0 of the direction's control register) at 0, no capture happens in that direction, whatever the other mode bits are.
- R6: A receive packet qualifies by Ethertype only when bits 3 and 4 of receive control are both 1 and `rx_ethertype` equals the value at address 2.
- R7: A receive packet qualifies as an event message when bit 5 of receive control is 1, `rx_ip_proto` is 17, and `rx_udp_dport` is 319.
- R8: With bit 2 of receive control set, every enabled receive start-of-frame qualifies, whatever its header fields.
- R9: Reset clears both stamps, both valid flags and all control and Ethertype registers.
- R10: A high-word read and a strobe in the same cycle on a locked slot release the slot and do not capture; the slot is empty after that edge.
- R11: Writes to addresses 3 to 7 are ignored, and a write to a valid bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype | input | 16 | Parsed Ethertype of the receive packet |
| rx_ip_proto | input | 8 | Parsed IP protocol number |
| rx_udp_dport | input | 16 | Parsed UDP destination port |
| time_now | input | 64 | Live time value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| tx_stamp | output | 64 | Captured transmit time |
| tx_valid | output | 1 | Transmit slot holds an unread stamp |
| rx_stamp | output | 64 | Captured receive time |
| rx_valid | output | 1 | Receive slot holds an unread stamp |

## Verification
The assertions assume three things about the inputs. The parsed header fields are valid in the same cycle as `rx_sof`. A strobe is a single-cycle pulse per frame. `reg_wr` and `reg_rd` are never both asserted. The stimulus drives the header fields together with each receive strobe and drops every strobe after one cycle. It issues register accesses one at a time, which keeps the capture, hold and release checks meaningful. The random phase draws header values from a small set so that Ethertype and port matches and near-misses both occur often.

// File: rtl/pkt_stamp_pkg.sv
`timescale 1ns/1ps
package pkt_stamp_pkg;
    localparam int DATA_W  = 32;
    localparam int TIME_W  = 2 * DATA_W;
    localparam int ADDR_W  = 3;
    localparam int ETYPE_W = 16;
    localparam int PROTO_W = 8;
    localparam int PORT_W  = 16;
    localparam int N_DIR   = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    localparam logic [PROTO_W-1:0] PROTO_UDP  = 8'd17;
    localparam logic [PORT_W-1:0]  EVENT_PORT = 16'd319;

    localparam int BIT_EN    = 0;
    localparam int BIT_VALID = 1;
    localparam int BIT_ALL   = 2;
    localparam int BIT_L2F   = 3;
    localparam int BIT_L2S   = 4;
    localparam int BIT_L4    = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_TX_CTL = 3'd0,
        A_RX_CTL = 3'd1,
        A_ETYPE  = 3'd2,
        A_TX_LO  = 3'd3,
        A_TX_HI  = 3'd4,
        A_RX_LO  = 3'd5,
        A_RX_HI  = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic l4_en;
        logic l2_stamp;
        logic l2_filt;
        logic all_mode;
        logic en;
    } rx_cfg_t;

    function automatic logic [DATA_W-1:0] rx_ctl_word(rx_cfg_t c, logic v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_EN]    = c.en;
        w[BIT_VALID] = v;
        w[BIT_ALL]   = c.all_mode;
        w[BIT_L2F]   = c.l2_filt;
        w[BIT_L2S]   = c.l2_stamp;
        w[BIT_L4]    = c.l4_en;
        return w;
    endfunction

    function automatic rx_cfg_t rx_ctl_decode(logic [DATA_W-1:0] w);
        rx_cfg_t c;
        c.en       = w[BIT_EN];
        c.all_mode = w[BIT_ALL];
        c.l2_filt  = w[BIT_L2F];
        c.l2_stamp = w[BIT_L2S];
        c.l4_en    = w[BIT_L4];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] stamp_word(logic [TIME_W-1:0] t, logic hi);
        return hi ? t[TIME_W-1:DATA_W] : t[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/pkt_stamp_slot.sv
`timescale 1ns/1ps
module pkt_stamp_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              rel_i,
    input  logic [TIME_W-1:0] time_i,
    output logic [TIME_W-1:0] stamp_o,
    output logic              valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_o <= '0;
            valid_o <= 1'b0;
        end else if (valid_o) begin
            if (rel_i) valid_o <= 1'b0;
        end else if (arm_i) begin
            stamp_o <= time_i;
            valid_o <= 1'b1;
        end
    end

    assert_locked_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !rel_i) |=> (valid_o && $stable(stamp_o)));

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && arm_i) |=> (valid_o && stamp_o == $past(time_i)));

    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && rel_i) |=> !valid_o);

    assert_no_capture_on_release_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_o && rel_i && arm_i) |=> (!valid_o && $stable(stamp_o)));
endmodule

// File: rtl/pkt_stamp_rxqual.sv
`timescale 1ns/1ps
module pkt_stamp_rxqual
    import pkt_stamp_pkg::*;
(
    input  rx_cfg_t              cfg_i,
    input  logic [ETYPE_W-1:0]   etype_cfg_i,
    input  logic [ETYPE_W-1:0]   etype_i,
    input  logic [PROTO_W-1:0]   proto_i,
    input  logic [PORT_W-1:0]    dport_i,
    output logic                 hit_o
);
    logic l2_hit, l4_hit;

    always_comb begin
        l2_hit = cfg_i.l2_filt && cfg_i.l2_stamp && (etype_i == etype_cfg_i);
        l4_hit = cfg_i.l4_en && (proto_i == PROTO_UDP) && (dport_i == EVENT_PORT);
        hit_o  = cfg_i.en && (cfg_i.all_mode || l2_hit || l4_hit);
    end
endmodule

// File: rtl/pkt_stamp_regs.sv
`timescale 1ns/1ps
module pkt_stamp_regs
    import pkt_stamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [N_DIR-1:0]    valid_i,
    input  logic [TIME_W-1:0]   tx_stamp_i,
    input  logic [TIME_W-1:0]   rx_stamp_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                tx_en_o,
    output rx_cfg_t             rx_cfg_o,
    output logic [ETYPE_W-1:0]  etype_o,
    output logic [N_DIR-1:0]    rel_o
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_o  <= 1'b0;
            rx_cfg_o <= '0;
            etype_o  <= '0;
        end else if (wr_i) begin
            case (a)
                A_TX_CTL: tx_en_o  <= wdata_i[BIT_EN];
                A_RX_CTL: rx_cfg_o <= rx_ctl_decode(wdata_i);
                A_ETYPE:  etype_o  <= wdata_i[ETYPE_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rel_o          = '0;
        rel_o[DIR_TX]  = rd_i && (a == A_TX_HI);
        rel_o[DIR_RX]  = rd_i && (a == A_RX_HI);
    end

    always_comb begin
        rdata_o = '0;
        case (a)
            A_TX_CTL: begin
                rdata_o[BIT_EN]    = tx_en_o;
                rdata_o[BIT_VALID] = valid_i[DIR_TX];
            end
            A_RX_CTL: rdata_o = rx_ctl_word(rx_cfg_o, valid_i[DIR_RX]);
            A_ETYPE:  rdata_o[ETYPE_W-1:0] = etype_o;
            A_TX_LO:  rdata_o = stamp_word(tx_stamp_i, 1'b0);
            A_TX_HI:  rdata_o = stamp_word(tx_stamp_i, 1'b1);
            A_RX_LO:  rdata_o = stamp_word(rx_stamp_i, 1'b0);
            A_RX_HI:  rdata_o = stamp_word(rx_stamp_i, 1'b1);
            default:  rdata_o = '0;
        endcase
    end

    assert_tx_ctl_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == A_TX_CTL) |=> (tx_en_o == $past(wdata_i[BIT_EN])));

    assert_ro_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i > A_ETYPE) |=> ($stable(tx_en_o) && $stable(rx_cfg_o) && $stable(etype_o)));
endmodule

// File: rtl/pkt_stamp_capture.sv
`timescale 1ns/1ps
module pkt_stamp_capture
    import pkt_stamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_sof,
    input  logic                rx_sof,
    input  logic [15:0]         rx_ethertype,
    input  logic [7:0]          rx_ip_proto,
    input  logic [15:0]         rx_udp_dport,
    input  logic [63:0]         time_now,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [63:0]         tx_stamp,
    output logic                tx_valid,
    output logic [63:0]         rx_stamp,
    output logic                rx_valid
);
    logic               tx_en;
    rx_cfg_t            rx_cfg;
    logic [ETYPE_W-1:0] etype_cfg;
    logic               rx_hit;
    logic [N_DIR-1:0]   arm, rel, valid;
    logic [TIME_W-1:0]  stamp [N_DIR];

    pkt_stamp_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr),
        .rd_i       (reg_rd),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .valid_i    (valid),
        .tx_stamp_i (stamp[DIR_TX]),
        .rx_stamp_i (stamp[DIR_RX]),
        .rdata_o    (reg_rdata),
        .tx_en_o    (tx_en),
        .rx_cfg_o   (rx_cfg),
        .etype_o    (etype_cfg),
        .rel_o      (rel)
    );

    pkt_stamp_rxqual u_qual (
        .cfg_i       (rx_cfg),
        .etype_cfg_i (etype_cfg),
        .etype_i     (rx_ethertype),
        .proto_i     (rx_ip_proto),
        .dport_i     (rx_udp_dport),
        .hit_o       (rx_hit)
    );

    always_comb begin
        arm         = '0;
        arm[DIR_TX] = tx_sof && tx_en;
        arm[DIR_RX] = rx_sof && rx_hit;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_slot
        pkt_stamp_slot #(.TIME_W(TIME_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .arm_i   (arm[d]),
            .rel_i   (rel[d]),
            .time_i  (time_now),
            .stamp_o (stamp[d]),
            .valid_o (valid[d])
        );
    end

    assign tx_stamp = stamp[DIR_TX];
    assign rx_stamp = stamp[DIR_RX];
    assign tx_valid = valid[DIR_TX];
    assign rx_valid = valid[DIR_RX];

    assert_tx_needs_sof_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(tx_sof));

    assert_rx_needs_sof_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(rx_sof));

    assert_rx_off_no_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (!rx_cfg.en && !rx_valid) |=> !rx_valid);
endmodule

// File: tb/pkt_stamp_capture_test.sv
`timescale 1ns/1ps
module pkt_stamp_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_sof = 1'b0, rx_sof = 1'b0;
    logic [15:0] rx_ethertype = '0;
    logic [7:0]  rx_ip_proto = '0;
    logic [15:0] rx_udp_dport = '0;
    logic [63:0] time_now = 64'h0000_0000_0000_0100;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] tx_stamp, rx_stamp;
    logic        tx_valid, rx_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) time_now <= time_now + 64'h0000_0001_2345_6789;

    pkt_stamp_capture uut (.*);

    // behavioural reference model
    bit        m_tx_en, m_en, m_all, m_l2f, m_l2s, m_l4;
    bit [15:0] m_etype;
    bit        m_tx_v, m_rx_v, m_txa, m_rxa;
    bit [63:0] m_tx_s, m_rx_s;

    always @(posedge clk) begin
        if (rst) begin
            {m_tx_en, m_en, m_all, m_l2f, m_l2s, m_l4} = '0;
            m_etype = '0; m_tx_v = 0; m_rx_v = 0; m_tx_s = '0; m_rx_s = '0;
        end else begin
            m_txa = tx_sof && m_tx_en;
            m_rxa = rx_sof && m_en && (m_all ||
                    (m_l2f && m_l2s && rx_ethertype == m_etype) ||
                    (m_l4 && rx_ip_proto == 8'd17 && rx_udp_dport == 16'd319));
            if (m_tx_v) begin
                if (reg_rd && reg_addr == 3'd4) m_tx_v = 0;
            end else if (m_txa) begin
                m_tx_s = time_now; m_tx_v = 1;
            end
            if (m_rx_v) begin
                if (reg_rd && reg_addr == 3'd6) m_rx_v = 0;
            end else if (m_rxa) begin
                m_rx_s = time_now; m_rx_v = 1;
            end
            if (reg_wr) begin
                if (reg_addr == 3'd0) m_tx_en = reg_wdata[0];
                if (reg_addr == 3'd1) begin
                    m_en = reg_wdata[0]; m_all = reg_wdata[2]; m_l2f = reg_wdata[3];
                    m_l2s = reg_wdata[4]; m_l4 = reg_wdata[5];
                end
                if (reg_addr == 3'd2) m_etype = reg_wdata[15:0];
            end
        end
    end

    function automatic logic [31:0] exp_rdata(logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_tx_v, m_tx_en};
            3'd1: return {26'd0, m_l4, m_l2s, m_l2f, m_all, m_rx_v, m_en};
            3'd2: return {16'd0, m_etype};
            3'd3: return m_tx_s[31:0];
            3'd4: return m_tx_s[63:32];
            3'd5: return m_rx_s[31:0];
            3'd6: return m_rx_s[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R1 tx_valid", tx_valid, m_tx_v);
        check("R1 rx_valid", rx_valid, m_rx_v);
        check("R2 tx_stamp", tx_stamp, m_tx_s);
        check("R2 rx_stamp", rx_stamp, m_rx_s);
        check("R3 rdata", reg_rdata, exp_rdata(reg_addr));
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        tick();
        reg_rd = 0;
    endtask

    task automatic tx_pkt();
        tx_sof = 1; tick(); tx_sof = 0;
    endtask

    task automatic rx_pkt(logic [15:0] et, logic [7:0] pr, logic [15:0] dp);
        rx_ethertype = et; rx_ip_proto = pr; rx_udp_dport = dp;
        rx_sof = 1; tick(); rx_sof = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        check("R9 tx_valid", tx_valid, 0);
        check("R9 rx_valid", rx_valid, 0);
        check("R9 tx_stamp", tx_stamp, 0);
        check("R9 rx_stamp", rx_stamp, 0);
        rd_reg(3'd0, d); check("R9 tx ctl", d, 0);
        rd_reg(3'd1, d); check("R9 rx ctl", d, 0);
        rd_reg(3'd2, d); check("R9 etype", d, 0);

        // R5: transmit disabled
        tx_pkt(); check("R5 tx disabled", tx_valid, 0);

        // R2: transmit capture
        wr_reg(3'd0, 32'h1);
        tx_pkt(); check("R2 tx captured", tx_valid, 1);
        held = tx_stamp;
        check("R2 stamp nonzero", (held != 0), 1);
        rd_reg(3'd0, d); check("R3 tx ctl valid bit", d, 32'h3);

        // R1: locked slot ignores strobes
        tx_pkt(); tx_pkt();
        check("R1 held stamp", tx_stamp, held);
        check("R1 still valid", tx_valid, 1);

        // R4: low read keeps slot, high read frees it
        rd_reg(3'd3, d); check("R4 low word", d, held[31:0]);
        check("R4 low read keeps lock", tx_valid, 1);
        rd_reg(3'd4, d); check("R4 high word", d, held[63:32]);
        check("R4 high read frees", tx_valid, 0);

        // R11: writes to read-only locations ignored
        wr_reg(3'd3, 32'hDEAD_BEEF);
        wr_reg(3'd0, 32'h3);
        rd_reg(3'd0, d); check("R11 valid not writable", d, 32'h1);
        check("R11 stamp unchanged", tx_stamp, held);

        // R10: release and strobe in same cycle
        tx_pkt(); check("R10 relock", tx_valid, 1);
        held = tx_stamp;
        reg_rd = 1; reg_addr = 3'd4; tx_sof = 1;
        tick();
        reg_rd = 0; tx_sof = 0;
        check("R10 slot empty", tx_valid, 0);
        check("R10 stamp kept", tx_stamp, held);

        // R6: Ethertype qualification
        wr_reg(3'd2, 32'h88F7);
        wr_reg(3'd1, 32'h19);
        rx_pkt(16'h0800, 8'd17, 16'd319); check("R6 etype miss", rx_valid, 0);
        rx_pkt(16'h88F7, 8'd0, 16'd0); check("R6 etype hit", rx_valid, 1);
        rd_reg(3'd6, d); check("R6 freed", rx_valid, 0);
        wr_reg(3'd1, 32'h09);
        rx_pkt(16'h88F7, 8'd0, 16'd0); check("R6 stamp enable off", rx_valid, 0);

        // R7: UDP event qualification
        wr_reg(3'd1, 32'h21);
        rx_pkt(16'h0800, 8'd6, 16'd319); check("R7 wrong proto", rx_valid, 0);
        rx_pkt(16'h0800, 8'd17, 16'd320); check("R7 wrong port", rx_valid, 0);
        rx_pkt(16'h88F7, 8'd17, 16'd319); check("R7 event hit", rx_valid, 1);
        held = rx_stamp;
        rx_pkt(16'h0800, 8'd17, 16'd319); check("R1 rx held", rx_stamp, held);
        rd_reg(3'd5, d); check("R4 rx low word", d, held[31:0]);
        rd_reg(3'd6, d); check("R4 rx high word", d, held[63:32]);

        // R8: stamp-all mode
        wr_reg(3'd1, 32'h05);
        rx_pkt(16'h1234, 8'd1, 16'd7); check("R8 all mode", rx_valid, 1);
        rd_reg(3'd6, d);

        // R5: receive disabled with every mode bit
        wr_reg(3'd1, 32'h3C);
        rx_pkt(16'h88F7, 8'd17, 16'd319); check("R5 rx disabled", rx_valid, 0);

        // random phase, compared to the model every cycle
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            tx_sof = ($urandom_range(0, 3) == 0);
            rx_sof = ($urandom_range(0, 2) == 0);
            rx_ethertype = ($urandom_range(0, 1) == 0) ? 16'h88F7 : 16'h0800;
            rx_ip_proto  = ($urandom_range(0, 1) == 0) ? 8'd17 : 8'd6;
            rx_udp_dport = ($urandom_range(0, 1) == 0) ? 16'd319 : 16'd320;
            reg_addr = 3'($urandom_range(0, 7));
            reg_rd = (r < 4);
            reg_wr = (r == 9) && (reg_addr < 3'd3 || $urandom_range(0, 3) == 0);
            reg_wdata = (reg_addr == 3'd2) ? (($urandom_range(0, 1) == 0) ? 32'h88F7 : 32'h0800)
                                           : 32'($urandom);
            if (reg_wr) reg_rd = 0;
            tick();
        end
        tx_sof = 0; rx_sof = 0; reg_rd = 0; reg_wr = 0;
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule